// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit holds the 64-bit product register pair (upper word HI, lower word LO) that a 32-bit processor core uses for wide multiplication. An issued operation multiplies two 32-bit operands, signed or unsigned. The 64-bit product then does one of three things: it replaces the pair, it is added to the pair, or it is subtracted from the pair. A two-bit accumulate control picks which.

The product runs through a short internal pipeline of `MUL_LAT` stages. While any operation is in flight, the unit raises `busy`. In the last cycle before the pair is written, it raises `commit`. A plain multiply offers its result on a forwarding port in that cycle. An accumulating operation never does. Instead it flags `commit_nofwd`, so a consumer has to wait until the pair itself is updated.

Read requests for either half are granted only while the unit is idle. Move-style writes can replace HI or LO on its own. The surrounding core is expected to use `rd_grant` to stall dependent reads.

Top module: `hilo_mac`

## Requirements
- R1: A synchronous active-low reset clears HI and LO to zero and leaves `busy`, `commit`, `fwd_valid` and `commit_nofwd` low.
- R2: With `iss_acc` = 2'b00 (overwrite), the pair becomes the 64-bit product. With `iss_signed` = 1 both operands are two's complement; with `iss_signed` = 0 both are zero-extended.
- R3: With `iss_acc` = 2'b01 (add) and `iss_signed` = 1, the new pair is the old pair plus the signed product. A signed add of 0x10000 times 0x10000 into a cleared pair gives HI = 0x1, LO = 0x0.
- R4: With `iss_acc` = 2'b01 and `iss_signed` = 0, the new pair is the old pair plus the unsigned product.
- R5: With `iss_acc` = 2'b11 (minus one, subtract), the new pair is the old pair minus the product, in both signed and unsigned forms.
- R6: The 64-bit add and subtract wrap modulo 2^64 and raise no error indication.
- R7: `busy` rises in the cycle after an issue and stays high for `MUL_LAT` cycles. `commit` is high only in the last of those cycles. The pair shows the new value in the cycle after `commit`, when `busy` is low again.
- R8: `rd_grant` is high exactly when `rd_req` is high and `busy` is low. `rd_data` gives HI when `rd_sel_hi` = 1 and LO otherwise.
- R9: In the commit cycle of an overwrite, `fwd_valid` is high and `fwd_data` carries the product. In the commit cycle of an add or subtract, `fwd_valid` is low and `commit_nofwd` is high.
- R10: `wr_hi` replaces HI only and `wr_lo` replaces LO only, each with `wr_data`, while `busy` is low. Writes presented while `busy` is high have no effect.
- R11: The unused control code `iss_acc` = 2'b10 behaves as overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue an operation this cycle |
| iss_signed | input | 1 | 1: signed operands, 0: unsigned |
| iss_acc | input | 2 | 00 overwrite, 01 add, 11 subtract, 10 overwrite |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| busy | output | 1 | An operation is in flight |
| commit | output | 1 | The pair is written at the next edge |
| commit_nofwd | output | 1 | The committing result must not be forwarded |
| fwd_valid | output | 1 | The committing result may be forwarded |
| fwd_data | output | 64 | Committing 64-bit result |
| wr_hi | input | 1 | Replace HI with wr_data |
| wr_lo | input | 1 | Replace LO with wr_data |
| wr_data | input | 32 | Data for move writes |
| rd_req | input | 1 | Read request |
| rd_sel_hi | input | 1 | 1 reads HI, 0 reads LO |
| rd_grant | output | 1 | Read accepted this cycle |
| rd_data | output | 32 | Selected half |

## Verification
A wrong accumulate mode, a wrong product sign or a lost carry between LO and HI stays hidden while the operation is in flight. It shows up on the first granted read after `busy` falls, which is `MUL_LAT` + 1 cycles after issue. A staging register that keeps a stale valid bit shows at once as `busy` that never drops, or as a second `commit` pulse. A leak of accumulate results onto the forwarding path shows in the single commit cycle, through `fwd_valid`. Every test therefore reads both halves straight after the operation finishes and samples the handshake flags cycle by cycle.

// File: rtl/hilo_mac_pkg.sv
// Shared types for the HI/LO multiply-accumulate unit.
// Assumes the two-bit accumulate control is read as a signed step (-1, 0, +1).
package hilo_mac_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_ADD  = 2'b01,
        ACC_RSVD = 2'b10,
        ACC_SUB  = 2'b11
    } acc_mode_e;

    // Fold the unused code into plain overwrite.
    function automatic acc_mode_e norm_mode(input logic [1:0] code);
        return (code == 2'b10) ? ACC_NONE : acc_mode_e'(code);
    endfunction
endpackage

// File: rtl/hilo_mac_mul.sv
// Multiplier with a LAT-deep result pipeline.
// Forms the product at issue time and carries product and mode through LAT
// stages. Assumes LAT >= 1 and a mode already normalised by the caller.
module hilo_mac_mul
    import hilo_mac_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_signed,
    input  acc_mode_e       in_mode,
    input  logic [DW-1:0]   in_a,
    input  logic [DW-1:0]   in_b,
    output logic            out_valid,
    output acc_mode_e       out_mode,
    output logic [2*DW-1:0] out_prod,
    output logic            any_valid
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] ext_a, ext_b, prod_now;
    logic          vld_q  [LAT];
    acc_mode_e     mode_q [LAT];
    logic [PW-1:0] prod_q [LAT];

    // Extend the operands to full width and keep the low PW bits of the product.
    always_comb begin
        ext_a    = {{DW{in_signed & in_a[DW-1]}}, in_a};
        ext_b    = {{DW{in_signed & in_b[DW-1]}}, in_b};
        prod_now = ext_a * ext_b;
    end

    for (genvar s = 0; s < LAT; s++) begin : g_stg
        if (s == 0) begin : g_head
            // First stage captures a newly issued operation.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0]  <= 1'b0;
                    mode_q[0] <= ACC_NONE;
                    prod_q[0] <= '0;
                end else begin
                    vld_q[0]  <= in_valid;
                    mode_q[0] <= in_mode;
                    prod_q[0] <= prod_now;
                end
            end
        end else begin : g_tail
            // Later stages shift the operation forward by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s]  <= 1'b0;
                    mode_q[s] <= ACC_NONE;
                    prod_q[s] <= '0;
                end else begin
                    vld_q[s]  <= vld_q[s-1];
                    mode_q[s] <= mode_q[s-1];
                    prod_q[s] <= prod_q[s-1];
                end
            end
        end
    end

    // Any occupied stage means the unit is busy.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < LAT; s++) any_valid = any_valid | vld_q[s];
    end

    assign out_valid = vld_q[LAT-1];
    assign out_mode  = mode_q[LAT-1];
    assign out_prod  = prod_q[LAT-1];
endmodule

// File: rtl/hilo_mac_acc.sv
// Combines the old pair with a product: overwrite, add or subtract.
// Arithmetic wraps modulo 2^PW. Purely combinational.
module hilo_mac_acc
    import hilo_mac_pkg::*;
#(
    parameter int PW = 64
) (
    input  acc_mode_e     mode,
    input  logic [PW-1:0] old_pair,
    input  logic [PW-1:0] prod,
    output logic [PW-1:0] new_pair
);
    // Select the result by the accumulate step.
    always_comb begin
        unique case (mode)
            ACC_ADD: new_pair = old_pair + prod;
            ACC_SUB: new_pair = old_pair - prod;
            default: new_pair = prod;
        endcase
    end
endmodule

// File: rtl/hilo_mac_regs.sv
// HI/LO storage. A commit writes the whole pair. Move writes replace one half
// only when mv_en is high. The caller keeps commit and mv_en apart.
module hilo_mac_regs #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cm_valid,
    input  logic [2*DW-1:0] cm_value,
    input  logic            mv_en,
    input  logic            mv_hi,
    input  logic            mv_lo,
    input  logic [DW-1:0]   mv_data,
    output logic [DW-1:0]   hi_o,
    output logic [DW-1:0]   lo_o
);
    // Update the pair from a commit, otherwise from enabled move writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= '0;
            lo_o <= '0;
        end else if (cm_valid) begin
            hi_o <= cm_value[2*DW-1:DW];
            lo_o <= cm_value[DW-1:0];
        end else if (mv_en) begin
            if (mv_hi) hi_o <= mv_data;
            if (mv_lo) lo_o <= mv_data;
        end
    end
endmodule

// File: rtl/hilo_mac.sv
// Top of the HI/LO multiply-accumulate unit.
// Issues go into a MUL_LAT-stage multiplier. The result is merged with the pair
// in the final stage. Accumulate results are flagged as not forwardable.
// Reads and move writes are accepted only while no operation is in flight.
module hilo_mac
    import hilo_mac_pkg::*;
#(
    parameter int DW      = 32,
    parameter int MUL_LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic            iss_signed,
    input  logic [1:0]      iss_acc,
    input  logic [DW-1:0]   iss_a,
    input  logic [DW-1:0]   iss_b,
    output logic            busy,
    output logic            commit,
    output logic            commit_nofwd,
    output logic            fwd_valid,
    output logic [2*DW-1:0] fwd_data,
    input  logic            wr_hi,
    input  logic            wr_lo,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_req,
    input  logic            rd_sel_hi,
    output logic            rd_grant,
    output logic [DW-1:0]   rd_data
);
    localparam int PW = 2 * DW;

    acc_mode_e     in_mode, fin_mode;
    logic [PW-1:0] fin_prod, new_pair;
    logic [DW-1:0] hi_q, lo_q;

    assign in_mode = norm_mode(iss_acc);

    hilo_mac_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .in_valid(iss_valid), .in_signed(iss_signed), .in_mode(in_mode),
        .in_a(iss_a), .in_b(iss_b),
        .out_valid(commit), .out_mode(fin_mode), .out_prod(fin_prod),
        .any_valid(busy)
    );

    hilo_mac_acc #(.PW(PW)) u_acc (
        .mode(fin_mode), .old_pair({hi_q, lo_q}), .prod(fin_prod),
        .new_pair(new_pair)
    );

    hilo_mac_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cm_valid(commit), .cm_value(new_pair),
        .mv_en(~busy), .mv_hi(wr_hi), .mv_lo(wr_lo), .mv_data(wr_data),
        .hi_o(hi_q), .lo_o(lo_q)
    );

    // Forwarding flags: only overwrite results may be forwarded.
    always_comb begin
        fwd_valid    = commit & (fin_mode == ACC_NONE);
        commit_nofwd = commit & (fin_mode != ACC_NONE);
        fwd_data     = new_pair;
    end

    // Read port: held off while any operation is in flight.
    always_comb begin
        rd_grant = rd_req & ~busy;
        rd_data  = rd_sel_hi ? hi_q : lo_q;
    end
endmodule

// File: rtl/hilo_mac_chk.sv
// Assertion checker bound to hilo_mac. Watches the handshakes and the pair.
module hilo_mac_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          commit,
    input logic          commit_nofwd,
    input logic          fwd_valid,
    input logic          rd_req,
    input logic          rd_grant,
    input logic [DW-1:0] hi_q,
    input logic [DW-1:0] lo_q
);
    p_commit_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    p_fwd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, commit_nofwd}));

    p_fwd_needs_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid || commit_nofwd) |-> commit);

    p_grant_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> (rd_req && !busy));

    p_pair_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind hilo_mac hilo_mac_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit),
    .commit_nofwd(commit_nofwd), .fwd_valid(fwd_valid),
    .rd_req(rd_req), .rd_grant(rd_grant), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/hilo_mac_bench.sv
// Directed bench for hilo_mac: one task per scenario.
module hilo_mac_bench;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0, iss_signed = 1'b0;
    logic [1:0]  iss_acc = 2'b00;
    logic [31:0] iss_a = '0, iss_b = '0;
    logic        busy, commit, commit_nofwd, fwd_valid;
    logic [63:0] fwd_data;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0, rd_sel_hi = 1'b0;
    logic        rd_grant;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic        s_fwdv, s_nofwd;
    logic [63:0] s_fwdd;

    always #4 clk = ~clk;

    hilo_mac #(.DW(32), .MUL_LAT(LAT)) u_hilo_mac (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL R7 watchdog: actual hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input bit sgn);
        longint sa, sb;
        if (sgn) begin
            sa = longint'(int'(a)); sb = longint'(int'(b));
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    // Read the whole pair through the read port (unit must be idle).
    task automatic rd_pair(output logic [63:0] p);
        @(negedge clk);
        rd_req = 1'b1; rd_sel_hi = 1'b1; #1;
        p[63:32] = rd_data;
        rd_sel_hi = 1'b0; #1;
        p[31:0] = rd_data;
        rd_req = 1'b0;
    endtask

    task automatic set_pair(input logic [63:0] p);
        @(negedge clk);
        wr_hi = 1'b1; wr_lo = 1'b0; wr_data = p[63:32];
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = p[31:0];
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    // Issue one operation, capture commit-cycle flags, wait for idle.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit sgn, input logic [1:0] acc);
        int guard;
        @(negedge clk);
        iss_valid = 1'b1; iss_a = a; iss_b = b; iss_signed = sgn; iss_acc = acc;
        @(negedge clk);
        iss_valid = 1'b0;
        guard = 0;
        while (!commit && guard < 20) begin @(negedge clk); guard++; end
        s_fwdv = fwd_valid; s_nofwd = commit_nofwd; s_fwdd = fwd_data;
        while (busy && guard < 40) begin @(negedge clk); guard++; end
    endtask

    task automatic t_reset;
        logic [63:0] p;
        chk("R1 busy", {63'b0, busy}, 64'd0);
        chk("R1 commit", {62'b0, commit, fwd_valid | commit_nofwd}, 64'd0);
        rd_pair(p);
        chk("R1 pair", p, 64'd0);
    endtask

    task automatic t_plain;
        logic [63:0] p;
        set_pair(64'h1234_5678_9ABC_DEF0);
        do_op(32'hFFFF_FFFD, 32'd5, 1'b1, 2'b00);
        rd_pair(p);
        chk("R2 signed mult", p, 64'hFFFF_FFFF_FFFF_FFF1);
        chk("R9 fwd valid plain", {63'b0, s_fwdv}, 64'd1);
        chk("R9 fwd data plain", s_fwdd, 64'hFFFF_FFFF_FFFF_FFF1);
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'b00);
        rd_pair(p);
        chk("R2 unsigned mult", p, 64'hFFFF_FFFE_0000_0001);
    endtask

    task automatic t_madd;
        logic [63:0] p;
        set_pair(64'd0);
        do_op(32'h0001_0000, 32'h0001_0000, 1'b1, 2'b01);
        rd_pair(p);
        chk("R3 madd example", p, 64'h0000_0001_0000_0000);
        chk("R9 no fwd on acc", {63'b0, s_fwdv}, 64'd0);
        chk("R9 nofwd flag", {63'b0, s_nofwd}, 64'd1);
        do_op(32'hFFFF_FFFF, 32'd1, 1'b1, 2'b01);
        rd_pair(p);
        chk("R3 madd negative", p, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_maddu;
        logic [63:0] p;
        set_pair(64'h0000_0010_0000_0003);
        do_op(32'hFFFF_FFFF, 32'd2, 1'b0, 2'b01);
        rd_pair(p);
        chk("R4 maddu", p, 64'h0000_0010_0000_0003 + ref_prod(32'hFFFF_FFFF, 32'd2, 1'b0));
    endtask

    task automatic t_msub;
        logic [63:0] p;
        set_pair(64'h0000_0005_0000_0000);
        do_op(32'hFFFF_FFFE, 32'd3, 1'b1, 2'b11);
        rd_pair(p);
        chk("R5 msub signed", p, 64'h0000_0005_0000_0006);
        chk("R9 nofwd on msub", {63'b0, s_nofwd}, 64'd1);
        do_op(32'hFFFF_FFFE, 32'd3, 1'b0, 2'b11);
        rd_pair(p);
        chk("R5 msubu", p, 64'h0000_0005_0000_0006 - ref_prod(32'hFFFF_FFFE, 32'd3, 1'b0));
    endtask

    task automatic t_wrap;
        logic [63:0] p;
        set_pair(64'hFFFF_FFFF_FFFF_FFFF);
        do_op(32'd1, 32'd1, 1'b0, 2'b01);
        rd_pair(p);
        chk("R6 add wrap", p, 64'd0);
        do_op(32'd1, 32'd1, 1'b1, 2'b11);
        rd_pair(p);
        chk("R6 sub wrap", p, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_timing;
        logic [63:0] p;
        set_pair(64'd7);
        @(negedge clk);
        iss_valid = 1'b1; iss_a = 32'd2; iss_b = 32'd3; iss_signed = 1'b0; iss_acc = 2'b01;
        rd_req = 1'b1; rd_sel_hi = 1'b0; #1;
        chk("R8 grant when idle", {63'b0, rd_grant}, 64'd1);
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            iss_valid = 1'b0; #1;
            chk("R7 busy in flight", {63'b0, busy}, 64'd1);
            chk("R7 commit timing", {63'b0, commit}, (k == LAT-1) ? 64'd1 : 64'd0);
            chk("R8 grant held off", {63'b0, rd_grant}, 64'd0);
        end
        @(negedge clk); #1;
        chk("R7 busy drops", {63'b0, busy}, 64'd0);
        chk("R8 grant after commit", {63'b0, rd_grant}, 64'd1);
        chk("R7 value visible", {32'b0, rd_data}, 64'd13);
        rd_req = 1'b0;
        rd_pair(p);
    endtask

    task automatic t_move;
        logic [63:0] p;
        set_pair(64'hAAAA_AAAA_5555_5555);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'h1111_2222;
        @(negedge clk);
        wr_hi = 1'b0;
        rd_pair(p);
        chk("R10 hi only", p, 64'h1111_2222_5555_5555);
        @(negedge clk);
        iss_valid = 1'b1; iss_a = 32'd0; iss_b = 32'd0; iss_signed = 1'b0; iss_acc = 2'b01;
        @(negedge clk);
        iss_valid = 1'b0; wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 32'hDEAD_BEEF;
        while (busy) @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
        rd_pair(p);
        chk("R10 busy write ignored", p, 64'h1111_2222_5555_5555);
    endtask

    task automatic t_rsvd;
        logic [63:0] p;
        set_pair(64'h0000_0009_0000_0009);
        do_op(32'd4, 32'd4, 1'b0, 2'b10);
        rd_pair(p);
        chk("R11 code 10 overwrites", p, 64'd16);
        chk("R11 code 10 forwards", {63'b0, s_fwdv}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_madd();
        t_maddu();
        t_msub();
        t_wrap();
        t_timing();
        t_move();
        t_rsvd();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule